// File: doc/BRIEF.md
# Translation Unit Control Register Bank

This block is the software-visible control and status register bank of an address-translation unit. Software reaches it through a plain register port that moves either one 32-bit word or an aligned pair of words (64 bits) per access. Each word carries three fixed per-bit masks. The writable mask selects which bits a store may replace. The write-one-to-clear mask selects bits that a 1 in the write data clears. The write-only mask selects bits that always read back as zero.

Above the plain storage, the bank handles two kinds of command. A global command word drives translation enable and the loading of the root table pointer, and each takes effect is acknowledged in a global status word. Two 64-bit invalidation command registers, one for the context cache and one for the translation cache, clear their own trigger bit as soon as they are written. They then write back the granularity that was actually performed. A hardware input sets bits in the fault status word, and software clears them by writing ones.

Top module: `xlat_csr_bank`

Word map (byte offset): 0x00 version, 0x04 global command, 0x08 global status, 0x0C fault status, 0x10/0x14 root table address low/high, 0x18/0x1C context command low/high, 0x20/0x24 translation-cache command low/high, 0x28 event control. A 64-bit access uses the pair that starts at the 8-byte aligned offset.

## Requirements
- R1: A write to a word gives new = ((old & ~W) | (d & W)) & ~(C & d), where W is the word's writable mask and C its write-one-to-clear mask. Writable masks: command 0xFF800000, root low/high 0xFFFFFFFF, context low 0xFFFFFFFF, context high 0xE0000000, cache low 0xFFFFFFFF, cache high 0xB0000000, event control 0x80000000, all others 0.
- R2: A read returns the stored word AND NOT its write-only mask. A 32-bit read returns zero in bits 63:32. A 64-bit read returns the high word in bits 63:32.
- R3: After synchronous reset, version reads 0x10, event control reads 0x80000000, and every other word reads 0. The xlate_en, root_ptr and rec_idx_clr outputs are 0.
- R4: Bits 31:23 of the global command word are writable, and they always read as zero.
- R5: A command write in which bit 31 differs from status bit 31 copies it into status bit 31 (xlate_en). When this change disables translation, rec_idx_clr pulses high for one cycle. A write that leaves bit 31 equal to status changes neither.
- R6: A command write with bit 30 set sets status bit 30. It also loads root_ptr with {root high, root low[31:12], 12'h0}. Otherwise root_ptr holds its value.
- R7: When a write that reaches the context high word leaves its bit 31 set, the block clears bit 31 in the same cycle. It also copies the requested code in bits 30:29 into bits 28:27 (1 global, 2 domain, 3 device, 0 unknown reports 0).
- R8: The translation-cache high word behaves the same way. Trigger is bit 31, request is bits 29:28, and the reported code goes to bits 26:25 (1 global, 2 domain, 3 page).
- R9: A command action runs only on a 64-bit write of the pair or a 32-bit write of the high word. A 32-bit write of the low word only stores data.
- R10: Fault status bits 0 and 4 are write-one-to-clear. hw_fsts_set ORs bits into the fault status word, and this takes priority over a clear in the same cycle. Other bits cannot be cleared by software.
- R11: An access whose last word lies at or beyond word 11 (offset 0x2C) reads as all ones and is ignored on write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; rdata is zero when low |
| wide | input | 1 | 1 = 64-bit access of an aligned pair |
| addr | input | ADDR_W | Byte offset |
| wdata | input | 64 | Write data (low word in 31:0) |
| rdata | output | 64 | Combinational read data |
| hw_fsts_set | input | 32 | Hardware set bits for fault status |
| xlate_en | output | 1 | Translation enabled status |
| root_ptr | output | 64 | Latched root table pointer |
| rec_idx_clr | output | 1 | One-cycle pulse: fault-record index reset |

## Verification
The bench aims at the mask formula, using random data on every word. If a design swapped the clear and write terms, or dropped write-only masking, its read-back would diverge from the model. Directed cases check the following. A repeated enable must not toggle or pulse anything. A disable must pulse the index clear. The root pointer must drop its low 12 bits. An unknown invalidation request must report 0, which a design that copied stale granularity would miss. Further cases cover a hardware set racing a software clear on fault status, and a 64-bit access straddling the end of the window, which a design checking only the first word would wrongly accept.

// File: rtl/xlat_csr_bank.sv
module xlat_csr_bank #(
  parameter int ADDR_W = 8,
  parameter int NREG = 11,
  parameter logic [31:0] VERSION = 32'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              wide,
  input  logic [ADDR_W-1:0] addr,
  input  logic [63:0]       wdata,
  output logic [63:0]       rdata,
  input  logic [31:0]       hw_fsts_set,
  output logic              xlate_en,
  output logic [63:0]       root_ptr,
  output logic              rec_idx_clr
);
  localparam int IW = $clog2(NREG);
  localparam int WW = ADDR_W - 1;
  localparam int GCMD = 1, GSTS = 2, FSTS = 3, RTLO = 4, RTHI = 5;
  localparam int CCHI = 7, TLHI = 9, FECTL = 10;

  function automatic logic [31:0] wmask(input int i);
    case (i)
      1: wmask = 32'hFF80_0000;
      4, 5, 6, 8: wmask = 32'hFFFF_FFFF;
      7: wmask = 32'hE000_0000;
      9: wmask = 32'hB000_0000;
      10: wmask = 32'h8000_0000;
      default: wmask = 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] w1cmask(input int i);
    w1cmask = (i == 3) ? 32'h11 : 32'h0;
  endfunction

  function automatic logic [31:0] womask(input int i);
    womask = (i == 1) ? 32'hFF80_0000 : 32'h0;
  endfunction

  function automatic logic [31:0] rstval(input int i);
    case (i)
      0: rstval = VERSION;
      10: rstval = 32'h8000_0000;
      default: rstval = 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d, input int i);
    merge = ((old & ~wmask(i)) | (d & wmask(i))) & ~(w1cmask(i) & d);
  endfunction

  logic [31:0] regs [NREG];
  logic [31:0] nxt  [NREG];
  logic [63:0] root_q;
  logic        clr_q;

  logic [WW-1:0] lo_w, hi_w;
  logic oor, cmd_wr, te_chg, srtp, cc_act, tl_act;

  assign lo_w = {1'b0, addr[ADDR_W-1:3], wide ? 1'b0 : addr[2]};
  assign hi_w = lo_w + WW'(wide);
  assign oor  = hi_w >= WW'(NREG);

  function automatic logic touched(input int i);
    touched = (lo_w == WW'(i)) || (wide && hi_w == WW'(i));
  endfunction

  assign cmd_wr = wr_en && !oor && touched(GCMD);
  assign cc_act = wr_en && !oor && touched(CCHI);
  assign tl_act = wr_en && !oor && touched(TLHI);

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      nxt[i] = regs[i];
      if (wr_en && !oor) begin
        if (lo_w == WW'(i)) nxt[i] = merge(regs[i], wdata[31:0], i);
        if (wide && hi_w == WW'(i)) nxt[i] = merge(regs[i], wdata[63:32], i);
      end
    end
    te_chg = cmd_wr && (regs[GSTS][31] ^ nxt[GCMD][31]);
    srtp   = cmd_wr && nxt[GCMD][30];
    if (te_chg) nxt[GSTS][31] = nxt[GCMD][31];
    if (srtp) nxt[GSTS][30] = 1'b1;
    if (cc_act && nxt[CCHI][31]) begin
      nxt[CCHI][31]    = 1'b0;
      nxt[CCHI][28:27] = nxt[CCHI][30:29];
    end
    if (tl_act && nxt[TLHI][31]) begin
      nxt[TLHI][31]    = 1'b0;
      nxt[TLHI][26:25] = nxt[TLHI][29:28];
    end
    nxt[FSTS] = nxt[FSTS] | hw_fsts_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= rstval(i);
      root_q <= '0;
      clr_q  <= 1'b0;
    end else begin
      for (int i = 0; i < NREG; i++) regs[i] <= nxt[i];
      if (srtp) root_q <= {nxt[RTHI], nxt[RTLO][31:12], 12'h000};
      clr_q <= te_chg && !nxt[GCMD][31];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (oor) rdata = '1;
      else begin
        rdata[31:0] = regs[lo_w[IW-1:0]] & ~womask(int'(lo_w));
        if (wide) rdata[63:32] = regs[hi_w[IW-1:0]] & ~womask(int'(hi_w));
      end
    end
  end

  assign xlate_en    = regs[GSTS][31];
  assign root_ptr    = root_q;
  assign rec_idx_clr = clr_q;

  assert_gcmd_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wide && addr == ADDR_W'(4)) |-> (rdata[31:23] == 9'h0));
  assert_te_follows_cmd_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wide && addr == ADDR_W'(4)) |=> (xlate_en == $past(wdata[31])));
  assert_clr_on_disable_R5: assert property (@(posedge clk) disable iff (rst)
    rec_idx_clr |-> (!xlate_en && $past(xlate_en)));
  assert_root_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !cmd_wr |=> $stable(root_ptr));
  assert_cc_selfclear_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wide && addr == ADDR_W'(28)) |=> !regs[CCHI][31]);
  assert_tl_selfclear_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wide && addr == ADDR_W'(36)) |=> !regs[TLHI][31]);
  assert_oor_no_effect_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && oor) |=> ($stable(xlate_en) && $stable(regs[FECTL])));
endmodule

// File: tb/xlat_csr_bank_test.sv
module xlat_csr_bank_test;
  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0, wide = 0;
  logic [7:0] addr = 0;
  logic [63:0] wdata = 0, rdata;
  logic [31:0] hw_fsts_set = 0;
  logic xlate_en, rec_idx_clr;
  logic [63:0] root_ptr;
  int checks = 0, errors = 0;
  logic [31:0] mdl [11];

  xlat_csr_bank uut (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .wide(wide),
    .addr(addr), .wdata(wdata), .rdata(rdata), .hw_fsts_set(hw_fsts_set),
    .xlate_en(xlate_en), .root_ptr(root_ptr), .rec_idx_clr(rec_idx_clr));

  always #5 clk = ~clk;

  function automatic logic [31:0] bw(input int i);
    case (i)
      1: bw = 32'hFF80_0000;
      4, 5, 6, 8: bw = 32'hFFFF_FFFF;
      7: bw = 32'hE000_0000;
      9: bw = 32'hB000_0000;
      10: bw = 32'h8000_0000;
      default: bw = 0;
    endcase
  endfunction
  function automatic logic [31:0] bc(input int i);
    bc = (i == 3) ? 32'h11 : 0;
  endfunction
  function automatic logic [31:0] bmerge(input logic [31:0] o, input logic [31:0] d, input int i);
    bmerge = ((o & ~bw(i)) | (d & bw(i))) & ~(bc(i) & d);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d, input logic w);
    @(negedge clk); addr = a; wdata = d; wide = w; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic w, output logic [63:0] v);
    @(negedge clk); addr = a; wide = w; rd_en = 1;
    #1 v = rdata; rd_en = 0;
  endtask

  task automatic do_reset();
    rst = 1; repeat (3) @(negedge clk); rst = 0;
    for (int i = 0; i < 11; i++) mdl[i] = 0;
    mdl[0] = 32'h10; mdl[10] = 32'h8000_0000;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] v;
    void'($urandom(32'd1234));
    do_reset();
    // R3 reset state
    rd(8'h00, 0, v); chk("R3 version", v, 64'h10);
    rd(8'h28, 0, v); chk("R3 event control", v, 64'h8000_0000);
    rd(8'h08, 0, v); chk("R3 status", v, 64'h0);
    chk("R3 outputs", {xlate_en, rec_idx_clr, root_ptr}, '0);
    // R4 / R5 enable
    wr(8'h04, 64'hFFFF_FFFF, 0);
    rd(8'h04, 0, v); chk("R4 cmd reads zero", v, 64'h0);
    rd(8'h08, 0, v); chk("R5 enable sets status", v, 64'hC000_0000);
    chk("R5 xlate_en", xlate_en, 1);
    wr(8'h10, 64'h0000_00AB_CDEF_1FFF, 1);
    wr(8'h04, 64'hC000_0000, 0);
    chk("R5 no pulse when unchanged", rec_idx_clr, 0);
    chk("R6 root latched", root_ptr, 64'h0000_00AB_CDEF_1000);
    rd(8'h10, 1, v); chk("R2 64-bit read", v, 64'h0000_00AB_CDEF_1FFF);
    wr(8'h10, 64'h5555_5555, 0);
    chk("R6 root holds", root_ptr, 64'h0000_00AB_CDEF_1000);
    wr(8'h04, 64'h0, 0);
    chk("R5 disable pulse", rec_idx_clr, 1);
    rd(8'h08, 0, v); chk("R5 disable clears TES", v, 64'h4000_0000);
    chk("R5 pulse one cycle", rec_idx_clr, 0);
    wr(8'h04, 64'h0, 0);
    chk("R5 repeat disable no pulse", rec_idx_clr, 0);
    // R7 context invalidation, 64-bit write
    wr(8'h18, {32'hC000_0000, 32'h1234}, 1);
    rd(8'h18, 1, v); chk("R7 domain granularity", v, {32'h5000_0000, 32'h1234});
    wr(8'h18, 64'h9999, 0);
    rd(8'h18, 1, v); chk("R9 low write stores only", v, {32'h5000_0000, 32'h9999});
    wr(8'h1C, 64'hE000_0000, 0);
    rd(8'h1C, 0, v); chk("R7 device granularity", v, 64'h7800_0000);
    wr(8'h1C, 64'h8000_0000, 0);
    rd(8'h1C, 0, v); chk("R7 unknown reports 0", v, 64'h0);
    // R8 translation cache
    wr(8'h24, 64'hB000_0000, 0);
    rd(8'h24, 0, v); chk("R8 page granularity", v, 64'h3600_0000);
    wr(8'h20, {32'h9000_0000, 32'h0}, 1);
    rd(8'h24, 0, v); chk("R8 global granularity R9 64-bit", v, 64'h1200_0000);
    // R10 fault status
    @(negedge clk); hw_fsts_set = 32'h13; @(negedge clk); hw_fsts_set = 0;
    rd(8'h0C, 0, v); chk("R10 hw set", v, 64'h13);
    wr(8'h0C, 64'h01, 0);
    rd(8'h0C, 0, v); chk("R10 clear bit0", v, 64'h12);
    wr(8'h0C, 64'hFFFF_FFFF, 0);
    rd(8'h0C, 0, v); chk("R10 only w1c bits clear", v, 64'h02);
    @(negedge clk); hw_fsts_set = 32'h10; addr = 8'h0C; wdata = 64'h10; wide = 0; wr_en = 1;
    @(negedge clk); wr_en = 0; hw_fsts_set = 0;
    rd(8'h0C, 0, v); chk("R10 set beats clear", v, 64'h12);
    // R1 event control and read-only version
    wr(8'h28, 64'h0, 0);
    rd(8'h28, 0, v); chk("R1 mask bit clears", v, 64'h0);
    wr(8'h28, 64'hFFFF_FFFF, 0);
    rd(8'h28, 0, v); chk("R1 only mask bit writable", v, 64'h8000_0000);
    wr(8'h00, 64'hFFFF_FFFF, 0);
    rd(8'h00, 0, v); chk("R1 version read-only", v, 64'h10);
    // R11 out of range
    rd(8'h2C, 0, v); chk("R11 oor read", v, '1);
    rd(8'h28, 1, v); chk("R11 straddling read", v, '1);
    wr(8'h28, 64'h0, 1);
    rd(8'h28, 0, v); chk("R11 straddling write ignored", v, 64'h8000_0000);
    wr(8'h2C, 64'h0, 0);
    rd(8'h28, 0, v); chk("R11 oor write ignored", v, 64'h8000_0000);

    // Random phase against the model
    do_reset();
    for (int n = 0; n < 400; n++) begin
      int k, wi;
      logic [31:0] d, d2;
      k = $urandom % 10;
      d = $urandom; d2 = $urandom;
      case (k)
        0: wi = 0; 1: wi = 3; 2: wi = 4; 3: wi = 5; 4: wi = 6;
        5: wi = 7; 6: wi = 8; 7: wi = 9; 8: wi = 10; default: wi = 4;
      endcase
      if (wi == 7 || wi == 9) d[31] = 1'b0;
      if (k == 9) begin
        wr(8'h10, {d2, d}, 1);
        mdl[4] = bmerge(mdl[4], d, 4); mdl[5] = bmerge(mdl[5], d2, 5);
        rd(8'h10, 1, v); chk("R1 R2 random 64-bit", v, {mdl[5], mdl[4]});
      end else begin
        wr(8'(wi * 4), {32'h0, d}, 0);
        mdl[wi] = bmerge(mdl[wi], d, wi);
        rd(8'(wi * 4), 0, v); chk("R1 random word", v, {32'h0, mdl[wi]});
      end
      if (n % 50 == 0) begin
        wr(8'(8'h2C + 8'(($urandom % 20) * 4)), {d2, d}, 0);
        rd(8'h28, 0, v); chk("R11 random oor write", v, {32'h0, mdl[10]});
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule